// File: doc/BRIEF.md
# Three-Product Recursive Unsigned Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product, with one level of recursive splitting. Each operand is cut into a high and a low half. The block does not form the four half-by-half products. It forms three: the two high halves multiplied, the two low halves multiplied, and the product of the two half-sums. Each half-sum is one bit wider than a half. The partial-product rows of all three sub-products go into a single carry-save compression tree. In that tree the high×high and low×low rows are also entered a second time, inverted, at the middle weight. This takes them away from the half-sum product without a separate subtractor. One carry-propagate addition at the end gives the product.

A mode input reuses the same tree as a pair of independent half-width multipliers. In this split mode the half-sum rows, the negative rows and the correction constant are all gated off. The high N bits of the output then hold the high-half product, and the low N bits hold the low-half product. A parameter selects a registered output (the default) or a purely combinational output.

Top module: `tri_split_mul`

## Requirements
- R1: With `mode_split` = 0, `prod` equals the unsigned product `a*b`, exact in 2N bits, for arbitrary operands.
- R2: With `mode_split` = 0 and both operands all ones, `prod` equals (2^N−1)^2. Both half-sums then carry out into their extra bit.
- R3: With `mode_split` = 0 and either operand zero, `prod` is zero, even though the negative-weight rows and the correction constant are still active.
- R4: With `mode_split` = 0 and an operand whose high half or low half is zero, `prod` still equals `a*b`.
- R5: With `mode_split` = 1, `prod[N-1:0]` equals `a[N/2-1:0]*b[N/2-1:0]`.
- R6: With `mode_split` = 1, `prod[2N-1:N]` equals `a[N-1:N/2]*b[N-1:N/2]`. No carry crosses from the low field into it.
- R7: With `REG_OUT` = 1, `prod` is zero while `rst_n` is low. It shows the result for the operands and mode sampled at a rising edge of `clk` from that edge on, and it holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| mode_split | input | 1 | 0: full N×N product; 1: two packed half-width products |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| prod | output | 2N | Product, or the two packed half products in split mode |

## Verification
The bench builds the block with N = 8 and sweeps every operand pair in both modes. Its expected values come from plain arithmetic on the operands. The full-mode sweep includes operands with a zero half. These show whether the middle-weight subtraction cancels exactly when one of the three sub-products vanishes. The all-ones pair shows whether the extra half-sum bit is weighted correctly. The zero operands show whether the inversion constant cancels the inverted rows exactly. The split-mode sweep compares each output field separately, so that a carry leaking across the field boundary, or a half-sum row left enabled, shows up in only one of the two fields. A hold check taken between clock edges confirms that the output changes only at the edge.

// File: rtl/tri_split_mul.sv
module tri_split_mul #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_split,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int H = N / 2;
  localparam int W = 2 * N;
  localparam int R = 5 * H + 2;

  initial begin
    if (N < 8 || (N % 2) != 0) $error("tri_split_mul: N must be even and at least 8");
  end

  logic [H-1:0] ah, al, bh, bl;
  logic [H:0]   sa, sb;
  logic         full;

  assign {ah, al} = a;
  assign {bh, bl} = b;
  assign sa   = {1'b0, ah} + {1'b0, al};
  assign sb   = {1'b0, bh} + {1'b0, bl};
  assign full = ~mode_split;

  logic [W-1:0] rows [R];

  always_comb begin
    for (int j = 0; j < H; j++) begin
      rows[j]       = W'(ah & {H{bh[j]}}) << (N + j);
      rows[H + j]   = W'(al & {H{bl[j]}}) << j;
      rows[2*H + j] = full ? ~(W'(ah & {H{bh[j]}}) << (H + j)) : '0;
      rows[3*H + j] = full ? ~(W'(al & {H{bl[j]}}) << (H + j)) : '0;
    end
    for (int j = 0; j <= H; j++) begin
      rows[4*H + j] = full ? (W'(sa & {(H+1){sb[j]}}) << (H + j)) : '0;
    end
    rows[R-1] = full ? W'(2 * H) : '0;
  end

  logic [W-1:0] sum_x, sum_y;

  always_comb begin
    logic [W-1:0] acc [R];
    logic [W-1:0] nxt [R];
    logic [W-1:0] x, y, z;
    int cnt, o;
    for (int i = 0; i < R; i++) acc[i] = rows[i];
    cnt = R;
    x = '0; y = '0; z = '0;
    for (int lvl = 0; lvl < R; lvl++) begin
      if (cnt > 2) begin
        for (int i = 0; i < R; i++) nxt[i] = '0;
        o = 0;
        for (int i = 0; i < R; i += 3) begin
          if (i + 2 < cnt) begin
            x = acc[i]; y = acc[i+1]; z = acc[i+2];
            nxt[o]     = x ^ y ^ z;
            nxt[o + 1] = ((x & y) | (x & z) | (y & z)) << 1;
            o = o + 2;
          end else begin
            if (i < cnt) begin
              nxt[o] = acc[i];
              o = o + 1;
            end
            if (i + 1 < cnt) begin
              nxt[o] = acc[i+1];
              o = o + 1;
            end
          end
        end
        for (int i = 0; i < R; i++) acc[i] = nxt[i];
        cnt = o;
      end
    end
    sum_x = acc[0];
    sum_y = acc[1];
  end

  logic [W-1:0] result;
  assign result = sum_x + sum_y;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod <= '0;
        else        prod <= result;
      end
    end else begin : g_comb
      assign prod = result;
    end
  endgenerate
endmodule

module tri_split_mul_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_split,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] prod
);
  localparam int H = N / 2;

  generate
    if (REG_OUT) begin : g_seq
      AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |=> prod == ({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)})); // R1
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_split && (a == '0 || b == '0)) |=> prod == '0); // R3
      AST_SPLIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |=> prod[N-1:0] == ({{H{1'b0}}, $past(a[H-1:0])} * {{H{1'b0}}, $past(b[H-1:0])})); // R5
      AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |=> prod[2*N-1:N] == ({{H{1'b0}}, $past(a[N-1:H])} * {{H{1'b0}}, $past(b[N-1:H])})); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> prod == '0); // R7
    end else begin : g_comb
      always_comb begin
        #0;
        if (!mode_split)
          AST_COMB_FULL: assert (prod == ({{N{1'b0}}, a} * {{N{1'b0}}, b})); // R1
        else
          AST_COMB_SPLIT: assert (prod == {ah_bh(a, b), al_bl(a, b)}); // R5 R6
      end
    end
  endgenerate

  function automatic logic [N-1:0] ah_bh(input logic [N-1:0] x, input logic [N-1:0] y);
    return {{H{1'b0}}, x[N-1:H]} * {{H{1'b0}}, y[N-1:H]};
  endfunction

  function automatic logic [N-1:0] al_bl(input logic [N-1:0] x, input logic [N-1:0] y);
    return {{H{1'b0}}, x[H-1:0]} * {{H{1'b0}}, y[H-1:0]};
  endfunction
endmodule

bind tri_split_mul tri_split_mul_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_tri_split_mul.sv
module tb_tri_split_mul;
  localparam int N = 8;
  localparam int H = N / 2;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_split = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic [W-1:0] prod;

  int total = 0;
  int bad = 0;
  bit pend = 0;
  logic         p_mode;
  logic [N-1:0] p_a, p_b;

  always #2.5 clk = ~clk;

  tri_split_mul #(.N(N), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .mode_split(mode_split),
    .a(a), .b(b), .prod(prod)
  );

  function automatic logic [W-1:0] full_ref(input logic [N-1:0] x, input logic [N-1:0] y);
    return {{N{1'b0}}, x} * {{N{1'b0}}, y};
  endfunction

  function automatic logic [N-1:0] half_ref(input logic [H-1:0] x, input logic [H-1:0] y);
    return {{H{1'b0}}, x} * {{H{1'b0}}, y};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_pending();
    string tag;
    if (!pend) return;
    if (p_mode) begin
      check("R5", {{N{1'b0}}, prod[N-1:0]}, {{N{1'b0}}, half_ref(p_a[H-1:0], p_b[H-1:0])});
      check("R6", {{N{1'b0}}, prod[W-1:N]}, {{N{1'b0}}, half_ref(p_a[N-1:H], p_b[N-1:H])});
    end else begin
      if (p_a == '0 || p_b == '0) tag = "R3";
      else if (p_a == '1 && p_b == '1) tag = "R2";
      else if (p_a[H-1:0] == '0 || p_a[N-1:H] == '0 ||
               p_b[H-1:0] == '0 || p_b[N-1:H] == '0) tag = "R4";
      else tag = "R1";
      check(tag, prod, full_ref(p_a, p_b));
    end
  endtask

  task automatic step(input logic m, input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    check_pending();
    mode_split = m; a = x; b = y;
    p_mode = m; p_a = x; p_b = y; pend = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode_split = 1'b0; a = 8'hFF; b = 8'hFF;
    repeat (3) @(negedge clk);
    check("R7", prod, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", prod, full_ref(8'hFF, 8'hFF));

    step(1'b0, 8'hFF, 8'hFF);
    step(1'b0, 8'h00, 8'hFF);
    step(1'b0, 8'hFF, 8'h00);
    step(1'b0, 8'hF0, 8'h0F);
    step(1'b0, 8'h0F, 8'hF0);
    step(1'b1, 8'hFF, 8'hFF);
    step(1'b0, 8'h81, 8'h7E);

    @(negedge clk);
    check_pending();
    pend = 0;
    mode_split = 1'b0; a = 8'h12; b = 8'h34;
    #1;
    check("R7", prod, full_ref(8'h81, 8'h7E));
    @(negedge clk);
    check("R7", prod, full_ref(8'h12, 8'h34));

    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        step(1'b0, N'(i), N'(j));
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        step(1'b1, N'(i), N'(j));
    @(negedge clk);
    check_pending();
    pend = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule